// File: doc/BRIEF.md
# Pipelined Float-to-Integer Ceiling Converter

This block turns a single-precision binary floating-point operand into a 32-bit signed two's-complement integer. It rounds every fractional value toward positive infinity. Any result that does not fit in the integer range is pinned to the nearest extreme instead of wrapping. Each result comes with a three-bit condition code that reports a discarded fraction, a clamped result, or an operand that is not a number.

The block is a three-stage pipeline with no stalls. An operand with its valid strobe may be offered on every clock. The matching result and its valid strobe appear three cycles later. The first stage splits and classifies the operand. The second stage moves the significand into a fixed-point frame and gathers the bits that fall below the binary point. The third stage applies the ceiling step, the sign, the clamp and the flags.

Top module: `f2i_ceil_pipe`

## Requirements
- R1: The operand is read as sign in bit 31, biased exponent in bits 30:23 with bias 127, and fraction in bits 22:0. The result is a 32-bit two's-complement integer.
- R2: A finite operand whose value is an integer in [-2^31+1, 2^31-1] converts exactly, and its flags are all zero.
- R3: A positive operand with a nonzero fraction converts to the next integer above it.
- R4: A negative operand with a nonzero fraction converts to the integer next toward zero (for example -1.5 gives -1).
- R5: Positive values in (0,1), positive denormals included, give 1. Negative values in (-1,0), negative denormals included, give 0. Zeros of either sign give 0 with no flags.
- R6: A positive operand of 2^31 or more, +Inf included, gives 0x7FFFFFFF with the saturated flag set.
- R7: A negative operand below -2^31, -Inf included, gives 0x80000000 with the saturated flag set. An operand of exactly -2^31 gives 0x80000000 with no flags.
- R8: A NaN of either sign gives 0 with only the invalid flag set.
- R9: The flags are bit 0 inexact, bit 1 saturated and bit 2 invalid. Inexact is set exactly when a nonzero fraction was discarded and the result was not clamped.
- R10: A result with out_valid high appears exactly 3 cycles after its operand was presented with in_valid high. Operands may be presented on consecutive cycles. A cycle without in_valid produces no out_valid.
- R11: A synchronous active-high reset drops out_valid and discards any operands already in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_fp | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe |
| out_int | output | 32 | Signed integer result |
| out_flags | output | 3 | Condition code: bit 2 invalid, bit 1 saturated, bit 0 inexact |

## Verification
The bench's corner cases are the sign-dependent ceiling step and the range edges. A design that rounded negative fractions away from zero would return -2 for -1.5. A design that dropped the sticky collection would return 0 instead of 1 for a positive denormal. Exactly -2^31 is the one in-range value with a 32-bit magnitude, so a careless clamp either flags it as saturated or wraps it. The values just below 2^31 and just below 2^23 exercise the top of the shifter and the last exponent that still has fraction bits. NaN inputs confirm that the invalid flag is never confused with the infinity path. Back-to-back issue, bubbles and a reset in mid-flight confirm that the valid timing is exact.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int FP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int INT_W   = 32;
    localparam int BIAS    = 127;
    localparam int MANT_W  = FRAC_W + 1;
    localparam int FIX_W   = 2 * INT_W;
    localparam int SH_W    = $clog2(FIX_W);
    // exponent field below which |x| < 0.5 (no integer bit reachable)
    localparam int TINY_LIM = BIAS - 1;
    // exponent field at which |x| >= 2^(INT_W-1)
    localparam int SAT_LIM  = BIAS + INT_W - 1;
    // shift that places the significand into a Q(INT_W).(INT_W) frame
    localparam int SH_OFF   = BIAS - (INT_W - FRAC_W);

    typedef enum logic [1:0] {
        K_FINITE   = 2'd0,
        K_NAN      = 2'd1,
        K_SAT      = 2'd2,
        K_MINEXACT = 2'd3
    } kind_e;

    typedef struct packed {
        logic              sign;
        kind_e             kind;
        logic              tiny;
        logic [SH_W-1:0]   shamt;
        logic [MANT_W-1:0] mant;
    } unpk_t;

    typedef struct packed {
        logic             sign;
        kind_e            kind;
        logic [INT_W-1:0] mag;
        logic             sticky;
    } algn_t;

    typedef struct packed {
        logic invalid;
        logic saturated;
        logic inexact;
    } ccode_t;

    function automatic logic [INT_W-1:0] clamp_value(input logic neg);
        return neg ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [FP_W-1:0] in_fp,
    output logic            out_valid,
    output unpk_t           out_u
);
    logic              sgn;
    logic [EXP_W-1:0]  efield;
    logic [FRAC_W-1:0] ffield;
    logic [EXP_W:0]    ediff;
    unpk_t             nxt;

    always_comb begin
        sgn    = in_fp[FP_W-1];
        efield = in_fp[FP_W-2 -: EXP_W];
        ffield = in_fp[FRAC_W-1:0];
        ediff  = {1'b0, efield} - (EXP_W+1)'(SH_OFF);

        nxt.sign  = sgn;
        nxt.mant  = {(efield != '0), ffield};
        nxt.tiny  = (int'(efield) < TINY_LIM);
        nxt.shamt = nxt.tiny ? '0 : ediff[SH_W-1:0];

        if (efield == '1)
            nxt.kind = (ffield != '0) ? K_NAN : K_SAT;
        else if (int'(efield) >= SAT_LIM)
            nxt.kind = (sgn && int'(efield) == SAT_LIM && ffield == '0) ? K_MINEXACT : K_SAT;
        else
            nxt.kind = K_FINITE;
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
        out_u <= nxt;
    end

    assert_stage1_follow_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_stage1_bubble_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  unpk_t in_u,
    output logic  out_valid,
    output algn_t out_a
);
    logic [FIX_W-1:0] wide;
    algn_t            nxt;

    always_comb begin
        wide       = FIX_W'(in_u.mant) << in_u.shamt;
        nxt.sign   = in_u.sign;
        nxt.kind   = in_u.kind;
        nxt.mag    = in_u.tiny ? '0 : wide[FIX_W-1:INT_W];
        nxt.sticky = in_u.tiny ? (in_u.mant != '0) : (wide[INT_W-1:0] != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
        out_a <= nxt;
    end

    assert_stage2_follow_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // finite operands never reach a 2^31 magnitude
    assert_mag_range_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_a.kind == K_FINITE) |-> !out_a.mag[INT_W-1]);

    // a fraction can only remain when the magnitude is below 2^FRAC_W
    assert_frac_small_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_a.kind == K_FINITE && out_a.sticky)
            |-> (out_a.mag < (INT_W)'(1 << FRAC_W)));

endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  algn_t            in_a,
    output logic             out_valid,
    output logic [INT_W-1:0] out_int,
    output ccode_t           out_cc
);
    logic [INT_W-1:0] bumped;
    logic [INT_W-1:0] res;
    ccode_t           cc;

    always_comb begin
        bumped = in_a.mag + INT_W'(in_a.sticky & ~in_a.sign);
        res    = '0;
        cc     = '0;
        unique case (in_a.kind)
            K_FINITE: begin
                res        = in_a.sign ? -bumped : bumped;
                cc.inexact = in_a.sticky;
            end
            K_NAN: begin
                cc.invalid = 1'b1;
            end
            K_SAT: begin
                res          = clamp_value(in_a.sign);
                cc.saturated = 1'b1;
            end
            K_MINEXACT: begin
                res = clamp_value(1'b1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
        out_int <= res;
        out_cc  <= cc;
    end

    assert_stage3_follow_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_sat_extreme_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cc.saturated)
            |-> (out_int == 32'h7FFF_FFFF || out_int == 32'h8000_0000));

    assert_nan_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cc.invalid)
            |-> (out_int == '0 && !out_cc.saturated && !out_cc.inexact));

    assert_inexact_unsat_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cc.inexact) |-> !out_cc.saturated);

    // a rounded result is always small, never the negative extreme
    assert_inexact_small_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cc.inexact) |-> (out_int != 32'h8000_0000));

endmodule

// File: rtl/f2i_ceil_pipe.sv
module f2i_ceil_pipe
    import f2i_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_fp,
    output logic        out_valid,
    output logic [31:0] out_int,
    output logic [2:0]  out_flags
);
    logic   s1_valid;
    unpk_t  s1_u;
    logic   s2_valid;
    algn_t  s2_a;
    ccode_t cc;

    f2i_unpack u_unpack (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_fp     (in_fp),
        .out_valid (s1_valid),
        .out_u     (s1_u)
    );

    f2i_align u_align (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s1_valid),
        .in_u      (s1_u),
        .out_valid (s2_valid),
        .out_a     (s2_a)
    );

    f2i_round u_round (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s2_valid),
        .in_a      (s2_a),
        .out_valid (out_valid),
        .out_int   (out_int),
        .out_cc    (cc)
    );

    assign out_flags = cc;

    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/sim_f2i_ceil_pipe.sv
module sim_f2i_ceil_pipe;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_fp = '0;
    logic        out_valid;
    logic [31:0] out_int;
    logic [2:0]  out_flags;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    f2i_ceil_pipe u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_fp     (in_fp),
        .out_valid (out_valid),
        .out_int   (out_int),
        .out_flags (out_flags)
    );

    // R1 field layout is exercised by every row of the table below
    localparam int N = 27;
    localparam logic [31:0] VIN [N] = '{
        32'h3F80_0000, 32'h3FC0_0000, 32'hBFC0_0000, 32'h3F00_0000, 32'hBF00_0000,
        32'h0000_0001, 32'h8000_0001, 32'h0000_0000, 32'h8000_0000, 32'h4F00_0000,
        32'h7F80_0000, 32'hFF80_0000, 32'hCF00_0000, 32'hCF00_0001, 32'h7FC0_0000,
        32'hFFFF_FFFF, 32'h4EFF_FFFF, 32'h4B00_0001, 32'h4AFF_FFFF, 32'hCAFF_FFFF,
        32'h4049_0FDB, 32'hC049_0FDB, 32'hC2F6_0000, 32'h7F7F_FFFF, 32'h3E80_0000,
        32'h007F_FFFF, 32'hBF80_0000 };
    localparam logic [31:0] VOUT [N] = '{
        32'h0000_0001, 32'h0000_0002, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000,
        32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h7FFF_FFFF,
        32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000,
        32'h0000_0000, 32'h7FFF_FF80, 32'h0080_0001, 32'h0080_0000, 32'hFF80_0001,
        32'h0000_0004, 32'hFFFF_FFFD, 32'hFFFF_FF85, 32'h7FFF_FFFF, 32'h0000_0001,
        32'h0000_0001, 32'hFFFF_FFFF };
    localparam logic [2:0] VFL [N] = '{
        3'd0, 3'd1, 3'd1, 3'd1, 3'd1,
        3'd1, 3'd1, 3'd0, 3'd0, 3'd2,
        3'd2, 3'd2, 3'd0, 3'd2, 3'd4,
        3'd4, 3'd0, 3'd0, 3'd1, 3'd1,
        3'd1, 3'd1, 3'd0, 3'd2, 3'd1,
        3'd1, 3'd0 };
    localparam string VREQ [N] = '{
        "R1", "R3", "R4", "R5", "R5",
        "R5", "R5", "R5", "R5", "R6",
        "R6", "R7", "R7", "R7", "R8",
        "R8", "R2", "R2", "R3", "R4",
        "R3", "R4", "R2", "R6", "R5",
        "R5", "R2" };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk("R11", {31'b0, out_valid}, 32'd0);
        rst = 1'b0;

        // table walk: operands issued back to back, results due 3 cycles later
        for (int c = 0; c < N + 3; c++) begin
            @(negedge clk);
            if (c >= 3) begin
                chk("R10", {31'b0, out_valid}, 32'd1);
                chk(VREQ[c-3], out_int, VOUT[c-3]);
                chk("R9", {29'b0, out_flags}, {29'b0, VFL[c-3]});
            end else begin
                chk("R10", {31'b0, out_valid}, 32'd0);
            end
            if (c < N) begin
                in_valid = 1'b1;
                in_fp    = VIN[c];
            end else begin
                in_valid = 1'b0;
                in_fp    = '0;
            end
        end

        // bubbles: no operand, so no result
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R10", {31'b0, out_valid}, 32'd0);
        end

        // a single isolated operand arrives on the third cycle exactly
        @(negedge clk);
        in_valid = 1'b1;
        in_fp    = 32'hC000_0000;   // -2.0
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R10", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R10", {31'b0, out_valid}, 32'd1);
        chk("R2", out_int, 32'hFFFF_FFFE);
        chk("R9", {29'b0, out_flags}, 32'd0);

        // reset while operands are in flight
        @(negedge clk);
        in_valid = 1'b1;
        in_fp    = 32'h3F80_0000;
        @(negedge clk);
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R11", {31'b0, out_valid}, 32'd0);
            @(negedge clk);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule